// File: doc/BRIEF.md
# Multi-Channel Edge-Programmed PWM Generator

This block drives up to sixteen PWM outputs from one shared timebase. A prescaler divides the clock into step ticks. A step counter counts those ticks to form the period. Every channel owns two compare values, a rise point and a fall point. The output goes high when the step counter reaches the rise point and low when it reaches the fall point. There is no duty-cycle register: the duty cycle follows from where the two edges sit.

Software reaches the block through a synchronous register port. It offers a write strobe, an address and write data, and read data that is always valid. The timebase settings and the enables take effect on the next clock. The edge values of a channel built with shadow storage can instead be held back while the synchronous-update bit is set. They then move into the active set only at the end of a period, so a period is never cut short or stretched by a half-finished update.

Each channel holds two small state machines. The output machine has the states OUT_LOW and OUT_HIGH. At the first clock of each step it moves OUT_LOW to OUT_HIGH on a rise match and OUT_HIGH to OUT_LOW on a fall match. A cleared enable forces it back to OUT_LOW from either state. The shadow machine has the states SH_IDLE and SH_PEND. A write while synchronous updating is on takes it from SH_IDLE to SH_PEND. A period boundary with no write in the same cycle returns it to SH_IDLE and copies the held values into the active set. Clearing the synchronous-update bit also returns it to SH_IDLE, without the copy.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset every output is low, every channel is disabled, and every register reads 0.
- R2: The prescaler counts 0..P and the step counter advances once per prescaler wrap, counting 0..S, so a period is (P+1)*(S+1) clocks. P is at address 0x00 and S is at 0x01. A counter already above a newly written limit wraps at its next count.
- R3: At the first clock of a step (prescaler at 0), a step count equal to the channel's rise value drives the output high, and a count equal to its fall value drives it low. The new level appears on the output after that clock edge.
- R4: When the rise and fall values are equal, each match flips the output. The result is a 50% waveform whose period is twice the programmed period.
- R5: An edge value greater than S is never matched. A rise value of S+1 with a fall value of 0 holds the output low, and a rise value of 0 with a fall value of S+1 holds it high.
- R6: Channel enables sit at address 0x04 (channels 0-7) and 0x05 (channels 8-15), with channel c at bit c mod 8. A disabled channel's output is low whatever its edge values.
- R7: For a channel without shadow storage, or when the synchronous-update bit (bit 0 of address 0x02) is clear, an edge write is active and readable from the next clock.
- R8: For a channel with shadow storage and the synchronous-update bit set, edge writes are held. They become active at the end of the current period, and reads return the previous active values until then.
- R9: The rise value of channel c is at address 0x20+2c and its fall value at 0x21+2c. Reads return the active values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pwm_o | output | NUM_CH | PWM outputs, bit c is channel c |

## Verification
The bench builds the block with ten channels and gives shadow storage to the even channels only. This places enables in both enable registers and puts direct and held channels side by side under the same writes. It sweeps prescale values 0 to 2 and period-step values 0 to 5 with edge values up to S+1. This reaches the equal-edge, never-matching and counter-wrap corners within a few dozen clocks each. A per-clock reference computed from the requirements is compared against every output on every cycle.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_PRESC     = 6'h00;
    localparam logic [ADDR_W-1:0] A_PERIOD    = 6'h01;
    localparam logic [ADDR_W-1:0] A_SYNC      = 6'h02;
    localparam logic [ADDR_W-1:0] A_EN_LO     = 6'h04;
    localparam logic [ADDR_W-1:0] A_EN_HI     = 6'h05;
    localparam logic [ADDR_W-1:0] A_EDGE_BASE = 6'h20;

    typedef enum logic {
        OUT_LOW,
        OUT_HIGH
    } out_state_e;

    typedef enum logic {
        SH_IDLE,
        SH_PEND
    } shadow_state_e;

endpackage

// File: rtl/pwm_edge_timebase.sv
module pwm_edge_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] presc,
    input  logic [W-1:0] per,
    output logic [W-1:0] pre_cnt,
    output logic [W-1:0] step_cnt,
    output logic         step_start,
    output logic         boundary
);

    logic pre_wrap;
    logic step_wrap;

    // ">=" so that a limit lowered below the running count wraps at once
    assign pre_wrap   = (pre_cnt >= presc);
    assign step_wrap  = (step_cnt >= per);
    assign step_start = (pre_cnt == '0);
    assign boundary   = pre_wrap && step_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            step_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt  <= '0;
            step_cnt <= step_wrap ? '0 : step_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
    import pwm_edge_pkg::*;
#(
    parameter int W          = 8,
    parameter bit HAS_SHADOW = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         sync_on,
    input  logic         wr_rise,
    input  logic         wr_fall,
    input  logic [W-1:0] wr_data,
    input  logic         step_start,
    input  logic [W-1:0] step_cnt,
    input  logic         boundary,
    output logic [W-1:0] rise_act,
    output logic [W-1:0] fall_act,
    output logic         pwm
);

    out_state_e    st_q, st_d;
    shadow_state_e sh_q, sh_d;
    logic [W-1:0]  rise_sh, fall_sh;
    logic          held;
    logic          wr_any;
    logic          hit_r, hit_f;

    assign held   = HAS_SHADOW && sync_on;
    assign wr_any = wr_rise || wr_fall;

    // output state machine: next state
    always_comb begin
        hit_r = (step_cnt == rise_act);
        hit_f = (step_cnt == fall_act);
        st_d  = st_q;
        if (!en) begin
            st_d = OUT_LOW;
        end else if (step_start) begin
            unique case (st_q)
                OUT_LOW:  if (hit_r) st_d = OUT_HIGH;
                OUT_HIGH: if (hit_f) st_d = OUT_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OUT_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        pwm = (st_q == OUT_HIGH) && en;
    end

    // shadow state machine: next state
    always_comb begin
        sh_d = sh_q;
        unique case (sh_q)
            SH_IDLE: if (held && wr_any) sh_d = SH_PEND;
            SH_PEND: begin
                if (!held)                     sh_d = SH_IDLE;
                else if (boundary && !wr_any)  sh_d = SH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= SH_IDLE;
            rise_sh  <= '0;
            fall_sh  <= '0;
            rise_act <= '0;
            fall_act <= '0;
        end else begin
            sh_q <= sh_d;
            if (wr_rise) rise_sh <= wr_data;
            if (wr_fall) fall_sh <= wr_data;
            if (!held) begin
                if (wr_rise) rise_act <= wr_data;
                if (wr_fall) fall_act <= wr_data;
            end else if (sh_q == SH_PEND && boundary) begin
                rise_act <= rise_sh;
                fall_act <= fall_sh;
            end
        end
    end

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
    import pwm_edge_pkg::*;
#(
    parameter int              NUM_CH      = 16,
    parameter logic [NUM_CH-1:0] SHADOW_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_o
);

    logic [DATA_W-1:0]   presc_q;
    logic [DATA_W-1:0]   per_q;
    logic                sync_q;
    logic [NUM_CH-1:0]   en_q;
    logic [2*DATA_W-1:0] en_pad;

    logic [DATA_W-1:0] pre_cnt;
    logic [DATA_W-1:0] step_cnt;
    logic              step_start;
    logic              boundary;

    logic [DATA_W-1:0] rise_act [NUM_CH];
    logic [DATA_W-1:0] fall_act [NUM_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            per_q   <= '0;
            sync_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                A_PRESC:  presc_q <= wr_data;
                A_PERIOD: per_q   <= wr_data;
                A_SYNC:   sync_q  <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // channel c lives in enable register c/8 at bit c%8
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_en && addr == A_EN_LO + ADDR_W'(c / 8))
                    en_q[c] <= wr_data[c % 8];
            end
        end
    end

    pwm_edge_timebase #(.W(DATA_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .presc      (presc_q),
        .per        (per_q),
        .pre_cnt    (pre_cnt),
        .step_cnt   (step_cnt),
        .step_start (step_start),
        .boundary   (boundary)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic wr_rise;
        logic wr_fall;

        assign wr_rise = wr_en && (addr == A_EDGE_BASE + ADDR_W'(2 * c));
        assign wr_fall = wr_en && (addr == A_EDGE_BASE + ADDR_W'(2 * c + 1));

        pwm_edge_chan #(
            .W          (DATA_W),
            .HAS_SHADOW (SHADOW_MASK[c])
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en_q[c]),
            .sync_on    (sync_q),
            .wr_rise    (wr_rise),
            .wr_fall    (wr_fall),
            .wr_data    (wr_data),
            .step_start (step_start),
            .step_cnt   (step_cnt),
            .boundary   (boundary),
            .rise_act   (rise_act[c]),
            .fall_act   (fall_act[c]),
            .pwm        (pwm_o[c])
        );
    end

    always_comb begin
        en_pad = '0;
        for (int c = 0; c < NUM_CH; c++) en_pad[c] = en_q[c];
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_PRESC:  rd_data = presc_q;
            A_PERIOD: rd_data = per_q;
            A_SYNC:   rd_data = {{(DATA_W-1){1'b0}}, sync_q};
            A_EN_LO:  rd_data = en_pad[DATA_W-1:0];
            A_EN_HI:  rd_data = en_pad[2*DATA_W-1:DATA_W];
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (addr == A_EDGE_BASE + ADDR_W'(2 * c))     rd_data = rise_act[c];
                    if (addr == A_EDGE_BASE + ADDR_W'(2 * c + 1)) rd_data = fall_act[c];
                end
            end
        endcase
    end

endmodule

// File: rtl/pwm_edge_chk.sv
module pwm_edge_chk
    import pwm_edge_pkg::*;
#(
    parameter int                NUM_CH      = 16,
    parameter logic [NUM_CH-1:0] SHADOW_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] pwm_o,
    input logic [NUM_CH-1:0] en_q,
    input logic [DATA_W-1:0] pre_cnt,
    input logic [DATA_W-1:0] step_cnt,
    input logic [DATA_W-1:0] presc_q,
    input logic [DATA_W-1:0] per_q,
    input logic              sync_q,
    input logic [DATA_W-1:0] rise_act [NUM_CH],
    input logic [DATA_W-1:0] fall_act [NUM_CH]
);

    logic at_end;
    assign at_end = (pre_cnt >= presc_q) && (step_cnt >= per_q);

    p_pre_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt >= presc_q) |=> (pre_cnt == '0));

    p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> (step_cnt == '0));

    p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt < presc_q) |=> $stable(step_cnt));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_a
        p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[c] |=> !pwm_o[c]);

        p_rise_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[c] && pre_cnt == '0 && step_cnt == rise_act[c] && step_cnt != fall_act[c])
            |=> (pwm_o[c] || !en_q[c]));

        p_fall_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_cnt == '0 && step_cnt == fall_act[c] && step_cnt != rise_act[c])
            |=> !pwm_o[c]);

        p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (SHADOW_MASK[c] && sync_q && !at_end)
            |=> ($stable(rise_act[c]) && $stable(fall_act[c])));
    end

endmodule

bind pwm_edge_gen pwm_edge_chk #(
    .NUM_CH      (NUM_CH),
    .SHADOW_MASK (SHADOW_MASK)
) i_pwm_edge_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_o    (pwm_o),
    .en_q     (en_q),
    .pre_cnt  (pre_cnt),
    .step_cnt (step_cnt),
    .presc_q  (presc_q),
    .per_q    (per_q),
    .sync_q   (sync_q),
    .rise_act (rise_act),
    .fall_act (fall_act)
);

// File: tb/test_pwm_edge_gen.sv
module test_pwm_edge_gen;

    localparam int             NCH = 10;
    localparam logic [NCH-1:0] SHM = 10'b01_0101_0101;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [5:0]     addr = '0;
    logic [7:0]     wr_data = '0;
    logic [7:0]     rd_data;
    logic [NCH-1:0] pwm_o;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  chk_on = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_edge_gen #(.NUM_CH(NCH), .SHADOW_MASK(SHM)) i_pwm_edge_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_o   (pwm_o)
    );

    // reference model built from the requirements
    int         m_pre, m_step;
    logic [7:0] m_presc, m_per;
    bit         m_sync;
    bit [NCH-1:0] m_en, m_st, m_pend;
    logic [7:0] m_ra [NCH];
    logic [7:0] m_fa [NCH];
    logic [7:0] m_rs [NCH];
    logic [7:0] m_fs [NCH];
    bit pw, sw, bnd, ss, wr_r, wr_f, shd, hr, hf;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre <= 0; m_step <= 0; m_presc <= 0; m_per <= 0; m_sync <= 0;
            m_en <= '0; m_st <= '0; m_pend <= '0;
            for (int c = 0; c < NCH; c++) begin
                m_ra[c] <= 0; m_fa[c] <= 0; m_rs[c] <= 0; m_fs[c] <= 0;
            end
        end else begin
            pw  = (m_pre >= int'(m_presc));
            sw  = (m_step >= int'(m_per));
            bnd = pw && sw;
            ss  = (m_pre == 0);
            if (pw) begin
                m_pre  <= 0;
                m_step <= sw ? 0 : m_step + 1;
            end else begin
                m_pre <= m_pre + 1;
            end
            if (wr_en && addr == 6'h00) m_presc <= wr_data;
            if (wr_en && addr == 6'h01) m_per <= wr_data;
            if (wr_en && addr == 6'h02) m_sync <= wr_data[0];
            for (int c = 0; c < NCH; c++) begin
                if (wr_en && addr == 6'(4 + c / 8)) m_en[c] <= wr_data[c % 8];
                wr_r = wr_en && addr == 6'(32 + 2 * c);
                wr_f = wr_en && addr == 6'(33 + 2 * c);
                shd  = SHM[c] && m_sync;
                if (!m_en[c]) m_st[c] <= 1'b0;
                else if (ss) begin
                    hr = (m_step == int'(m_ra[c]));
                    hf = (m_step == int'(m_fa[c]));
                    if (hr && hf)  m_st[c] <= !m_st[c];
                    else if (hr)   m_st[c] <= 1'b1;
                    else if (hf)   m_st[c] <= 1'b0;
                end
                if (wr_r) m_rs[c] <= wr_data;
                if (wr_f) m_fs[c] <= wr_data;
                if (!shd) begin
                    if (wr_r) m_ra[c] <= wr_data;
                    if (wr_f) m_fa[c] <= wr_data;
                end else if (m_pend[c] && bnd) begin
                    m_ra[c] <= m_rs[c];
                    m_fa[c] <= m_fs[c];
                end
                if (shd && (wr_r || wr_f)) m_pend[c] <= 1'b1;
                else if (!m_sync || bnd)   m_pend[c] <= 1'b0;
            end
        end
    end

    // every-cycle waveform comparison (R2 R3 R4 R5 R7 R8)
    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (pwm_o !== (m_st & m_en)) begin
                errors++;
                $display("FAIL R2 R3 R4 R5 R7 R8 waveform at cycle %0d: actual %b expected %b",
                         cyc, pwm_o, m_st & m_en);
            end
        end
    end

    task automatic check_val(string tag, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, input logic [5:0] a, input int exp_v);
        @(negedge clk);
        addr = a;
        #1;
        check_val(tag, int'(rd_data), exp_v);
    endtask

    task automatic count_high(input int idx, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            hi += int'(pwm_o[idx]);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            summary();
        end
    end

    initial begin
        int hi, t0, t1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R1 outputs in reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        rd_chk("R1 prescale reset", 6'h00, 0);
        rd_chk("R1 period reset", 6'h01, 0);
        rd_chk("R1 sync reset", 6'h02, 0);
        rd_chk("R1 enable low reset", 6'h04, 0);
        rd_chk("R1 enable high reset", 6'h05, 0);
        rd_chk("R1 rise ch0 reset", 6'h20, 0);
        rd_chk("R1 fall ch9 reset", 6'h33, 0);
        check_val("R1 outputs after reset", int'(pwm_o), 0);
        chk_on = 1'b1;

        wr(6'h04, 8'hFF);
        wr(6'h05, 8'h03);
        rd_chk("R6 enable low readback", 6'h04, 8'hFF);
        rd_chk("R6 enable high readback", 6'h05, 8'h03);

        // sweep prescale, period and edge placements, direct then held
        for (int sy = 0; sy < 2; sy++) begin
            wr(6'h02, 8'(sy));
            for (int p = 0; p < 3; p++) begin
                for (int qi = 0; qi < 5; qi++) begin
                    int q;
                    q = (qi == 4) ? 5 : qi;
                    wr(6'h00, 8'(p));
                    wr(6'h01, 8'(q));
                    for (int k = 0; k < 3; k++) begin
                        for (int c = 0; c < NCH; c++) begin
                            wr(6'(32 + 2 * c), 8'((c + k) % (q + 2)));
                            wr(6'(33 + 2 * c), 8'((3 * c + k + 1) % (q + 2)));
                        end
                        repeat (4 * (p + 1) * (q + 1) + 4) @(negedge clk);
                    end
                end
            end
        end

        wr(6'h02, 8'h00);
        wr(6'h27, 8'h5A);
        rd_chk("R9 fall ch3 readback", 6'h27, 8'h5A);

        // period length and held update
        wr(6'h00, 8'd20);
        wr(6'h01, 8'd20);
        wr(6'h24, 8'd0);
        wr(6'h25, 8'd1);
        wr(6'h20, 8'd2);
        wr(6'h22, 8'd2);
        repeat (1000) @(negedge clk);
        @(posedge pwm_o[2]); t0 = cyc;
        @(posedge pwm_o[2]); t1 = cyc;
        check_val("R2 period 21x21", t1 - t0, 441);
        wr(6'h02, 8'h01);
        rd_chk("R9 sync bit readback", 6'h02, 1);
        @(posedge pwm_o[2]);
        wr(6'h20, 8'd5);
        wr(6'h22, 8'd5);
        rd_chk("R8 held rise ch0 before boundary", 6'h20, 2);
        rd_chk("R7 direct rise ch1", 6'h22, 5);
        repeat (500) @(negedge clk);
        rd_chk("R8 held rise ch0 after boundary", 6'h20, 5);

        // equal edges, placed edges, never-matching edges
        wr(6'h02, 8'h00);
        wr(6'h00, 8'd0);
        wr(6'h01, 8'd3);
        wr(6'h28, 8'd1); wr(6'h29, 8'd1);
        wr(6'h2E, 8'd1); wr(6'h2F, 8'd3);
        wr(6'h2A, 8'd4); wr(6'h2B, 8'd0);
        wr(6'h2C, 8'd0); wr(6'h2D, 8'd4);
        wr(6'h30, 8'd0); wr(6'h31, 8'd2);
        repeat (20) @(negedge clk);
        @(posedge pwm_o[4]); t0 = cyc;
        @(posedge pwm_o[4]); t1 = cyc;
        check_val("R4 equal edges period doubled", t1 - t0, 8);
        count_high(4, 40, hi);
        check_val("R4 equal edges half high", hi, 20);
        count_high(7, 40, hi);
        check_val("R3 rise 1 fall 3 high time", hi, 20);
        count_high(5, 40, hi);
        check_val("R5 rise beyond period holds low", hi, 0);
        count_high(6, 40, hi);
        check_val("R5 fall beyond period holds high", hi, 40);
        count_high(8, 20, hi);
        check_val("R6 ch8 enabled toggles", hi, 10);
        wr(6'h05, 8'h02);
        count_high(8, 20, hi);
        check_val("R6 ch8 disabled held low", hi, 0);
        rd_chk("R6 enable high after clear", 6'h05, 8'h02);

        chk_on = 1'b0;
        done = 1'b1;
        summary();
    end

endmodule